// File: doc/BRIEF.md
# Write-Back Data Cache with Per-Word Valid Bits

This block is a direct-mapped data cache that sits between a processor's word load/store port and a memory that moves whole blocks. Stores are kept in the cache and mark the line dirty. A modified line is copied back to memory only when a different block needs its slot. A store that misses takes over the line without reading the rest of the block from memory. Each line therefore records, word by word, which words hold real data.

A load hits only when the stored tag matches and the addressed word is valid. A load whose tag matches but whose word is invalid fetches the block and fills in only the missing words. Words already written by the processor are kept. When a partly filled dirty line is evicted, only its valid words are written, under a per-word write mask. The processor holds its request until the cache acknowledges it. A hit is acknowledged in the cycle the request is presented. A miss holds the acknowledge low until the memory traffic has finished and the line can serve the access.

Top module: `wbcache_top`

## Requirements
- R1: After reset every line is invalid and clean, `cpu_ack` is low without a request, `mem_req` is low, and the first load to any address misses and issues one block read.
- R2: Address fields with default parameters: bits [1:0] select a byte and are ignored for word accesses, bits [3:2] select the word in the line, bits [6:4] are the line index (block address modulo 8 lines), and bits [11:7] are the tag.
- R3: A load whose line tag matches and whose word valid bit is set is acknowledged in the cycle it is presented, returns the cached word, and causes no memory traffic.
- R4: A load to a line holding a different tag, when that line is clean, issues one block read at the requested block's line address, returns the memory word, and leaves the line fully valid and clean.
- R5: A store to a matching line, or to a clean line of any tag, is acknowledged at once with no memory traffic and sets the line dirty. A later load of that word returns the stored value.
- R6: A store that replaces another block does not read the block from memory. Only the stored word becomes valid in the new line.
- R7: A load to an invalid word of a tag-matching line reads the block and writes memory data only into the invalid words. Previously stored words keep their values.
- R8: Before a dirty line holding a different tag is replaced, it is written to memory at its own line address, with `mem_wmask` bit w set exactly for the valid words w. Memory words under a clear mask bit are unchanged.
- R9: Replacing a clean line produces no memory write.
- R10: While a miss is being serviced, `cpu_ack` stays low and `mem_req`, `mem_we` and `mem_addr` are held until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request, held until acknowledged |
| cpu_we | input | 1 | 1 for store, 0 for load |
| cpu_addr | input | ADDR_W | Byte address of the word |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ack | output | 1 | Access completes at this clock edge |
| cpu_rdata | output | DATA_W | Load data, valid with `cpu_ack` |
| mem_req | output | 1 | Block transfer request |
| mem_we | output | 1 | 1 for block write, 0 for block read |
| mem_addr | output | ADDR_W | Line-aligned block address |
| mem_wdata | output | WORDS*DATA_W | Line data for a write, word w at bits w*DATA_W |
| mem_wmask | output | WORDS | Per-word write enable for a block write |
| mem_rdata | input | WORDS*DATA_W | Block read data, valid with `mem_ack` |
| mem_ack | input | 1 | One-cycle completion of the transfer |

## Verification
The bench targets a load that hits the tag of a line filled by stores but lands on an unwritten word. A design that treated a tag match as a hit would return stale data there. A design that fetched without merging would overwrite the stored words. Dirty evictions of partly filled lines are checked for the exact write mask and for untouched memory words, which catches a full-line write that clobbers memory with garbage. Store misses into clean and dirty lines are checked for the absence of a block read. Clean evictions are checked for the absence of a write, and the store and load data are checked against a flat memory model.

// File: rtl/wbcache_pkg.sv
package wbcache_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WB,
        ST_FILL
    } cstate_t;

    typedef enum logic [1:0] {
        META_NONE,
        META_STORE,
        META_FILL,
        META_CLEAN
    } meta_op_t;

endpackage

// File: rtl/wbcache_meta.sv
module wbcache_meta
    import wbcache_pkg::*;
#(
    parameter int LINES = 8,
    parameter int WORDS = 4,
    parameter int TAG_W = 5,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] idx,
    input  meta_op_t         op,
    input  logic [TAG_W-1:0] new_tag,
    input  logic [WORDS-1:0] word_sel,
    input  logic             keep,
    output logic [TAG_W-1:0] rd_tag,
    output logic [WORDS-1:0] rd_valid,
    output logic             rd_dirty
);

    logic [TAG_W-1:0] tag_q   [LINES];
    logic [WORDS-1:0] valid_q [LINES];
    logic             dirty_q [LINES];

    assign rd_tag   = tag_q[idx];
    assign rd_valid = valid_q[idx];
    assign rd_dirty = dirty_q[idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LINES; i++) begin
                valid_q[i] <= '0;
                dirty_q[i] <= 1'b0;
                tag_q[i]   <= '0;
            end
        end else begin
            unique case (op)
                META_STORE: begin
                    tag_q[idx]   <= new_tag;
                    valid_q[idx] <= (keep ? valid_q[idx] : '0) | word_sel;
                    dirty_q[idx] <= 1'b1;
                end
                META_FILL: begin
                    tag_q[idx]   <= new_tag;
                    valid_q[idx] <= '1;
                    dirty_q[idx] <= keep ? dirty_q[idx] : 1'b0;
                end
                META_CLEAN: begin
                    valid_q[idx] <= '0;
                    dirty_q[idx] <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // a dirty line always carries at least one valid word (R5)
    p_dirty_valid_r5: assert property (@(posedge clk) disable iff (rst)
        rd_dirty |-> (rd_valid != '0));

endmodule

// File: rtl/wbcache_data.sv
module wbcache_data #(
    parameter int LINES  = 8,
    parameter int WORDS  = 4,
    parameter int DATA_W = 32,
    localparam int IDX_W  = $clog2(LINES),
    localparam int LINE_W = WORDS * DATA_W
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  idx,
    input  logic              store_en,
    input  logic [WORDS-1:0]  word_sel,
    input  logic [DATA_W-1:0] wr_word,
    input  logic              fill_en,
    input  logic [WORDS-1:0]  fill_keep,
    input  logic [LINE_W-1:0] fill_line,
    output logic [LINE_W-1:0] rd_line
);

    for (genvar w = 0; w < WORDS; w++) begin : g_bank
        logic [DATA_W-1:0] bank [LINES];

        always_ff @(posedge clk) begin
            if (store_en && word_sel[w])
                bank[idx] <= wr_word;
            else if (fill_en && !fill_keep[w])
                bank[idx] <= fill_line[w*DATA_W +: DATA_W];
        end

        assign rd_line[w*DATA_W +: DATA_W] = bank[idx];
    end

endmodule

// File: rtl/wbcache_ctrl.sv
module wbcache_ctrl
    import wbcache_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cpu_req,
    input  logic     cpu_we,
    input  logic     line_match,
    input  logic     word_valid,
    input  logic     line_dirty,
    input  logic     mem_ack,
    output logic     cpu_ack,
    output logic     mem_req,
    output logic     mem_we,
    output logic     wb_phase,
    output meta_op_t meta_op,
    output logic     store_en,
    output logic     fill_en
);

    cstate_t state, nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    always_comb begin
        nxt      = state;
        cpu_ack  = 1'b0;
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        wb_phase = 1'b0;
        meta_op  = META_NONE;
        store_en = 1'b0;
        fill_en  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (cpu_we) begin
                        if (line_match || !line_dirty) begin
                            cpu_ack  = 1'b1;
                            store_en = 1'b1;
                            meta_op  = META_STORE;
                        end else begin
                            nxt = ST_WB;
                        end
                    end else if (line_match && word_valid) begin
                        cpu_ack = 1'b1;
                    end else if (!line_match && line_dirty) begin
                        nxt = ST_WB;
                    end else begin
                        nxt = ST_FILL;
                    end
                end
            end
            ST_WB: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                wb_phase = 1'b1;
                if (mem_ack) begin
                    meta_op = META_CLEAN;
                    nxt     = ST_IDLE;
                end
            end
            ST_FILL: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    meta_op = META_FILL;
                    fill_en = 1'b1;
                    nxt     = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // no completion while memory traffic is outstanding (R10)
    p_no_ack_busy_r10: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |-> !cpu_ack);

    // a fill never overwrites a dirty line of another block (R8)
    p_fill_after_wb_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FILL) |-> (line_match || !line_dirty));

    // acknowledge only answers a live request (R3)
    p_ack_has_req_r3: assert property (@(posedge clk) disable iff (rst)
        cpu_ack |-> cpu_req);

endmodule

// File: rtl/wbcache_top.sv
module wbcache_top
    import wbcache_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int LINES  = 8,
    parameter int WORDS  = 4,
    localparam int BYTE_W = $clog2(DATA_W / 8),
    localparam int WOFF_W = $clog2(WORDS),
    localparam int IDX_W  = $clog2(LINES),
    localparam int TAG_W  = ADDR_W - IDX_W - WOFF_W - BYTE_W,
    localparam int LINE_W = WORDS * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ack,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LINE_W-1:0] mem_wdata,
    output logic [WORDS-1:0]  mem_wmask,
    input  logic [LINE_W-1:0] mem_rdata,
    input  logic              mem_ack
);

    logic [TAG_W-1:0]  req_tag, rd_tag;
    logic [IDX_W-1:0]  req_idx;
    logic [WOFF_W-1:0] req_wof;
    logic [WORDS-1:0]  word_sel, rd_valid, fill_keep;
    logic              rd_dirty, line_match, word_valid;
    logic              wb_phase, store_en, fill_en;
    logic [LINE_W-1:0] rd_line;
    meta_op_t          meta_op;

    assign req_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
    assign req_idx  = cpu_addr[BYTE_W+WOFF_W +: IDX_W];
    assign req_wof  = cpu_addr[BYTE_W +: WOFF_W];
    assign word_sel = {{(WORDS-1){1'b0}}, 1'b1} << req_wof;

    assign line_match = (rd_tag == req_tag) && (rd_valid != '0);
    assign word_valid = (rd_valid & word_sel) != '0;
    assign fill_keep  = line_match ? rd_valid : '0;

    wbcache_meta #(.LINES(LINES), .WORDS(WORDS), .TAG_W(TAG_W)) u_meta (
        .clk      (clk),
        .rst      (rst),
        .idx      (req_idx),
        .op       (meta_op),
        .new_tag  (req_tag),
        .word_sel (word_sel),
        .keep     (line_match),
        .rd_tag   (rd_tag),
        .rd_valid (rd_valid),
        .rd_dirty (rd_dirty)
    );

    wbcache_data #(.LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W)) u_data (
        .clk       (clk),
        .idx       (req_idx),
        .store_en  (store_en),
        .word_sel  (word_sel),
        .wr_word   (cpu_wdata),
        .fill_en   (fill_en),
        .fill_keep (fill_keep),
        .fill_line (mem_rdata),
        .rd_line   (rd_line)
    );

    wbcache_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .cpu_req    (cpu_req),
        .cpu_we     (cpu_we),
        .line_match (line_match),
        .word_valid (word_valid),
        .line_dirty (rd_dirty),
        .mem_ack    (mem_ack),
        .cpu_ack    (cpu_ack),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .wb_phase   (wb_phase),
        .meta_op    (meta_op),
        .store_en   (store_en),
        .fill_en    (fill_en)
    );

    assign cpu_rdata = rd_line[req_wof*DATA_W +: DATA_W];
    assign mem_addr  = {(wb_phase ? rd_tag : req_tag), req_idx, {(WOFF_W+BYTE_W){1'b0}}};
    assign mem_wdata = rd_line;
    assign mem_wmask = wb_phase ? rd_valid : '0;

    // a write-back always carries at least one word (R8)
    p_wmask_nonzero_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (mem_wmask != '0));

    // an unanswered memory request holds its address (R10)
    p_mem_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

endmodule

// File: tb/wbcache_top_tb.sv
`timescale 1ns/1ps
module wbcache_top_tb;

    localparam int AW = 12;
    localparam int DW = 32;
    localparam int NW = 4;
    localparam int LW = NW * DW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cpu_req = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic          cpu_ack;
    logic [DW-1:0] cpu_rdata;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [LW-1:0] mem_wdata;
    logic [NW-1:0] mem_wmask;
    logic [LW-1:0] mem_rdata = '0;
    logic          mem_ack = 1'b0;

    always #2.5 clk = ~clk;

    wbcache_top u_dut (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack),
        .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wmask(mem_wmask),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    int n_chk = 0, n_fail = 0;
    logic [DW-1:0] bmem    [1024];
    logic [DW-1:0] ref_mem [1024];
    logic [DW-1:0] exp_q [$];
    string         tag_q [$];
    int            rd_cnt = 0, wr_cnt = 0;
    logic [NW-1:0] last_wmask = '0;
    logic [AW-1:0] last_waddr = '0;
    int            lat = 0;

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] mk(input int tg, input int ix, input int w);
        mk = {tg[4:0], ix[2:0], w[1:0], 2'b00};
    endfunction

    // memory model: three-cycle latency, one-cycle acknowledge
    always @(posedge clk) begin
        mem_ack <= 1'b0;
        if (rst) lat <= 0;
        else if (mem_req && !mem_ack) begin
            if (lat == 2) begin
                lat     <= 0;
                mem_ack <= 1'b1;
                if (mem_we) begin
                    for (int w = 0; w < NW; w++)
                        if (mem_wmask[w]) bmem[{mem_addr[AW-1:4], w[1:0]}] <= mem_wdata[w*DW +: DW];
                    wr_cnt     <= wr_cnt + 1;
                    last_wmask <= mem_wmask;
                    last_waddr <= mem_addr;
                end else begin
                    for (int w = 0; w < NW; w++)
                        mem_rdata[w*DW +: DW] <= bmem[{mem_addr[AW-1:4], w[1:0]}];
                    rd_cnt <= rd_cnt + 1;
                end
            end else lat <= lat + 1;
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        #2;
        if (cpu_req && cpu_ack && mem_req) chk(1'b0, "R10 ack during miss", 32'(cpu_ack), 32'h0);
        if (cpu_req && cpu_ack && !cpu_we) begin
            if (exp_q.size() == 0) chk(1'b0, "scoreboard underflow", cpu_rdata, 32'h0);
            else begin
                logic [DW-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(cpu_rdata === e, t, cpu_rdata, e);
            end
        end
    end

    task automatic do_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d, input string rq);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        if (we) ref_mem[a[AW-1:2]] = d;
        else begin
            exp_q.push_back(ref_mem[a[AW-1:2]]);
            tag_q.push_back(rq);
        end
        #1;
        while (!cpu_ack) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        cpu_req = 1'b0;
    endtask

    task automatic traffic(input int r0, input int w0, input int dr, input int dw, input string rq);
        chk(rd_cnt - r0 == dr, {rq, " block reads"}, 32'(rd_cnt - r0), 32'(dr));
        chk(wr_cnt - w0 == dw, {rq, " block writes"}, 32'(wr_cnt - w0), 32'(dw));
    endtask

    initial begin
        repeat (30000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        int r0, w0;
        for (int i = 0; i < 1024; i++) begin
            bmem[i]    = 32'hA000_0000 | i;
            ref_mem[i] = 32'hA000_0000 | i;
        end
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk); #1;
        chk(cpu_ack == 1'b0, "R1 ack idle", 32'(cpu_ack), 32'h0);
        chk(mem_req == 1'b0, "R1 mem_req idle", 32'(mem_req), 32'h0);

        // R1/R4: cold load misses with one read
        r0 = rd_cnt; w0 = wr_cnt;
        do_op(1'b0, mk(1, 0, 0), '0, "R4 cold load data");
        traffic(r0, w0, 1, 0, "R1");

        // R3: hit on another word of the filled line
        r0 = rd_cnt; w0 = wr_cnt;
        do_op(1'b0, mk(1, 0, 2), '0, "R3 hit data");
        traffic(r0, w0, 0, 0, "R3");

        // R5: store hit, no traffic, read back
        r0 = rd_cnt; w0 = wr_cnt;
        do_op(1'b1, mk(1, 0, 1), 32'h1111_0001, "R5");
        do_op(1'b0, mk(1, 0, 1), '0, "R5 store readback");
        traffic(r0, w0, 0, 0, "R5");

        // R6: store into empty line, no fetch
        r0 = rd_cnt; w0 = wr_cnt;
        do_op(1'b1, mk(2, 3, 2), 32'h2222_0002, "R6");
        traffic(r0, w0, 0, 0, "R6");

        // R7: load to invalid word of matching line merges
        r0 = rd_cnt; w0 = wr_cnt;
        do_op(1'b0, mk(2, 3, 0), '0, "R7 merged fetch data");
        traffic(r0, w0, 1, 0, "R7");
        r0 = rd_cnt;
        do_op(1'b0, mk(2, 3, 2), '0, "R7 stored word kept");
        traffic(r0, w0, 0, 0, "R7 kept word hit");

        // R8: full dirty eviction then reload of evicted block
        r0 = rd_cnt; w0 = wr_cnt;
        do_op(1'b0, mk(5, 0, 0), '0, "R8 load after writeback");
        traffic(r0, w0, 1, 1, "R8");
        chk(last_wmask == 4'b1111, "R8 full mask", 32'(last_wmask), 32'hF);
        chk(last_waddr == mk(1, 0, 0), "R8 writeback address", 32'(last_waddr), 32'(mk(1, 0, 0)));

        // R9: clean eviction, no write
        r0 = rd_cnt; w0 = wr_cnt;
        do_op(1'b0, mk(1, 0, 1), '0, "R9 reload of written-back word");
        traffic(r0, w0, 1, 0, "R9");

        // R8: partial dirty eviction writes masked words only
        r0 = rd_cnt; w0 = wr_cnt;
        do_op(1'b1, mk(3, 5, 1), 32'h3333_0001, "R6");
        do_op(1'b1, mk(3, 5, 3), 32'h3333_0003, "R6");
        traffic(r0, w0, 0, 0, "R6 two stores");
        do_op(1'b0, mk(4, 5, 0), '0, "R8 partial evict load");
        traffic(r0, w0, 1, 1, "R8 partial");
        chk(last_wmask == 4'b1010, "R8 partial mask", 32'(last_wmask), 32'hA);
        chk(last_waddr == mk(3, 5, 0), "R8 partial address", 32'(last_waddr), 32'(mk(3, 5, 0)));
        chk(bmem[mk(3, 5, 0) >> 2] == (32'hA000_0000 | 32'(mk(3, 5, 0) >> 2)),
            "R8 unmasked word untouched", bmem[mk(3, 5, 0) >> 2], 32'hA000_0000 | 32'(mk(3, 5, 0) >> 2));
        do_op(1'b0, mk(3, 5, 1), '0, "R8 masked word landed");
        do_op(1'b0, mk(3, 5, 0), '0, "R8 unmasked word original");

        // R5/R6/R8: store miss into dirty line: write back, no fetch
        do_op(1'b1, mk(3, 5, 2), 32'h3333_0002, "R5");
        r0 = rd_cnt; w0 = wr_cnt;
        do_op(1'b1, mk(7, 5, 0), 32'h7777_0000, "R6");
        traffic(r0, w0, 0, 1, "R6 store over dirty");
        chk(last_wmask == 4'b1111, "R8 mask after fill", 32'(last_wmask), 32'hF);
        r0 = rd_cnt; w0 = wr_cnt;
        do_op(1'b0, mk(7, 5, 0), '0, "R6 stored word hit");
        traffic(r0, w0, 0, 0, "R6 hit");
        do_op(1'b0, mk(7, 5, 1), '0, "R7 fetch beside stored word");
        traffic(r0, w0, 1, 0, "R7 second fetch");

        // R2: byte offset bits ignored
        do_op(1'b0, mk(7, 5, 0) | 12'h003, '0, "R2 byte bits ignored");
        do_op(1'b0, mk(2, 3, 2), '0, "R2 other index unaffected");

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "scoreboard drained", 32'(exp_q.size()), 32'h0);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule